// File: doc/BRIEF.md
# Chained Programmable Sync Waveform Generator Bank

This block is a bank of programmable timing counters that together produce the waveforms a display needs: horizontal sync, vertical sync, a line-active window and a pixel-active window. The block clock is the pixel clock. Each generator counts events from a source it selects. The source can be every pixel clock, or the event output of another generator in the bank. A line counter can therefore step on the horizontal generator, and a pixel window can be restarted by a line window.

Each generator has a period, a start offset counted on its own offset source, and a repeat limit (zero means run forever). It also has a clear source, and rising and falling pin positions given in half-pixel units. Every output pin has its own invert bit. Configuration is loaded through a plain write port and only while the bank is disabled. Raising the enable starts every generator from a cleared state in the same cycle, so all waveforms begin aligned.

Top module: `sync_wave_bank`

## Requirements
- R1: While reset is asserted or `bank_en` is low, every generator is idle: `gen_evt` is all zero and every `gen_pin` bit equals its invert bit. After reset all configuration and invert bits are zero.
- R2: A source code selects the event stream. Code 0 gives no events. Code 1 gives an event on every clock. Code c from 2 to NUM_GEN+1 gives the event output of generator c-1. Another generator's event is seen one clock after it appears on `gen_evt`.
- R3: With repeat field 0 a generator runs forever. With a nonzero repeat R it emits exactly R events, then stops with its pin inactive, and stays stopped until its clear source fires.
- R4: A running generator with period field P emits one event every P+1 events of its run source. The count position runs 0..P and restarts at 0 on the emitting event.
- R5: After a start or a clear, the first event is emitted on the (offset+1)-th event of the offset source, and the count position is then 0.
- R6: An event on the clear source returns the generator to waiting for its offset. This is checked before anything else in the same cycle.
- R7: The raw pin is high while running when up <= 2*position < down. The positions are in half-pixel units, so down 2*W (or 2*W-1) gives a pulse of W positions.
- R8: `gen_pin` bit k-1 is the raw pin of generator k XOR invert bit k-1.
- R9: Writes are ignored while `bank_en` is high. Every rising `bank_en` restarts all generators from the waiting state in the same cycle.
- R10: Register map. `wr_addr[1:0]` picks the word and the upper address bits pick the generator k (1..NUM_GEN). Word 0 holds period[11:0], offset[23:12], run source[27:24] and offset source[31:28]. Word 1 holds repeat[11:0] and clear source[15:12]. Word 2 holds up[9:0] and down[25:16]. Generator 0, word 0 holds the invert mask, with bit k-1 for generator k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_en | input | 1 | Run the bank; low means idle and configurable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | clog2(NUM_GEN+1)+2 | Generator index and word select |
| wr_data | input | 32 | Write data |
| gen_pin | output | NUM_GEN | Waveform outputs after invert |
| gen_evt | output | NUM_GEN | Registered event pulse of each generator |

## Verification
A free-running horizontal generator on the pixel clock checks the period, the half-unit pulse width and the auto-reload. An unconfigured generator on the same run shows that source code 0 stays silent. A windowed generator is cleared by that line event, with an offset and a finite repeat. It checks the one-clock chaining latency, the clear priority and that it stops after exactly R events. A slow counter stepped on the line event checks counting on another generator's output. Invert masks, writes made during a run and a second enable check that configuration is frozen while running and that the restart is aligned.

// File: rtl/sync_wave_pkg.sv
package sync_wave_pkg;
   localparam int CNT_W = 12;
   localparam int EDG_W = 10;
   localparam int SRC_W = 4;

   // word 0 field positions
   localparam int W0_PER = 0;
   localparam int W0_OFS = W0_PER + CNT_W;
   localparam int W0_RSRC = W0_OFS + CNT_W;
   localparam int W0_OSRC = W0_RSRC + SRC_W;
   // word 1
   localparam int W1_RPT = 0;
   localparam int W1_CLR = CNT_W;
   // word 2
   localparam int W2_UP = 0;
   localparam int W2_DN = 16;

   typedef struct packed {
      logic [CNT_W-1:0] period;
      logic [CNT_W-1:0] offset;
      logic [SRC_W-1:0] run_src;
      logic [SRC_W-1:0] off_src;
      logic [CNT_W-1:0] rpt;
      logic [SRC_W-1:0] clr_src;
      logic [EDG_W-1:0] up_pos;
      logic [EDG_W-1:0] dn_pos;
   } gen_cfg_t;

   typedef enum logic [1:0] {ST_WAIT, ST_RUN, ST_STOP} gen_state_t;
endpackage

// File: rtl/sync_wave_regs.sv
module sync_wave_regs
   import sync_wave_pkg::*;
#(
   parameter int NUM_GEN = 9,
   localparam int GI_W = $clog2(NUM_GEN + 1),
   localparam int AW = GI_W + 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           bank_en,
   input  logic           wr_en,
   input  logic [AW-1:0]  wr_addr,
   input  logic [31:0]    wr_data,
   output gen_cfg_t       cfg_q [NUM_GEN],
   output logic [NUM_GEN-1:0] inv_q
);
   logic [GI_W-1:0] gidx;
   logic [1:0]      wsel;
   logic            wr_ok;

   assign gidx  = wr_addr[AW-1:2];
   assign wsel  = wr_addr[1:0];
   assign wr_ok = wr_en && !bank_en;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         inv_q <= '0;
      end else if (wr_ok && gidx == '0 && wsel == 2'd0) begin
         inv_q <= wr_data[NUM_GEN-1:0];
      end
   end

   for (genvar k = 0; k < NUM_GEN; k++) begin : g_cfg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cfg_q[k] <= '0;
         end else if (wr_ok && int'(gidx) == k + 1) begin
            case (wsel)
               2'd0: begin
                  cfg_q[k].period  <= wr_data[W0_PER +: CNT_W];
                  cfg_q[k].offset  <= wr_data[W0_OFS +: CNT_W];
                  cfg_q[k].run_src <= wr_data[W0_RSRC +: SRC_W];
                  cfg_q[k].off_src <= wr_data[W0_OSRC +: SRC_W];
               end
               2'd1: begin
                  cfg_q[k].rpt     <= wr_data[W1_RPT +: CNT_W];
                  cfg_q[k].clr_src <= wr_data[W1_CLR +: SRC_W];
               end
               2'd2: begin
                  cfg_q[k].up_pos  <= wr_data[W2_UP +: EDG_W];
                  cfg_q[k].dn_pos  <= wr_data[W2_DN +: EDG_W];
               end
               default: ;
            endcase
         end
      end

      AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
         bank_en |=> $stable(cfg_q[k])); // R9
   end

   AST_INV_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      bank_en |=> $stable(inv_q)); // R9
endmodule

// File: rtl/sync_wave_gen.sv
module sync_wave_gen
   import sync_wave_pkg::*;
#(
   parameter int NUM_GEN = 9,
   localparam int POS_W = CNT_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  gen_cfg_t           cfg,
   input  logic [NUM_GEN-1:0] evt_all,
   output logic               evt_o,
   output logic               pin_o
);
   gen_state_t       st_q;
   logic [CNT_W-1:0] run_cnt_q;
   logic [CNT_W-1:0] off_cnt_q;
   logic [CNT_W-1:0] rep_cnt_q;
   logic             run_e, off_e, clr_e;
   logic [POS_W-1:0] pos;

   function automatic logic pick(input logic [SRC_W-1:0] code,
                                 input logic [NUM_GEN-1:0] ev);
      int c;
      c = int'(code);
      if (c == 1) return 1'b1;
      if (c >= 2 && c <= NUM_GEN + 1) return ev[c-2];
      return 1'b0;
   endfunction

   assign run_e = pick(cfg.run_src, evt_all);
   assign off_e = pick(cfg.off_src, evt_all);
   assign clr_e = pick(cfg.clr_src, evt_all);

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         st_q      <= ST_WAIT;
         run_cnt_q <= '0;
         off_cnt_q <= '0;
         rep_cnt_q <= '0;
         evt_o     <= 1'b0;
      end else begin
         evt_o <= 1'b0;
         if (clr_e) begin
            st_q      <= ST_WAIT;
            run_cnt_q <= '0;
            off_cnt_q <= '0;
            rep_cnt_q <= '0;
         end else begin
            case (st_q)
               ST_WAIT: if (off_e) begin
                  if (off_cnt_q == cfg.offset) begin
                     st_q      <= ST_RUN;
                     run_cnt_q <= '0;
                     rep_cnt_q <= CNT_W'(1);
                     evt_o     <= 1'b1;
                  end else begin
                     off_cnt_q <= off_cnt_q + 1'b1;
                  end
               end
               ST_RUN: if (run_e) begin
                  if (run_cnt_q == cfg.period) begin
                     run_cnt_q <= '0;
                     if (cfg.rpt != '0 && rep_cnt_q == cfg.rpt) begin
                        st_q <= ST_STOP;
                     end else begin
                        evt_o     <= 1'b1;
                        rep_cnt_q <= rep_cnt_q + 1'b1;
                     end
                  end else begin
                     run_cnt_q <= run_cnt_q + 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // position in half-pixel units
   assign pos   = {run_cnt_q, 1'b0};
   assign pin_o = (st_q == ST_RUN) && (pos >= POS_W'(cfg.up_pos))
                  && (pos < POS_W'(cfg.dn_pos));

   AST_RUN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      st_q == ST_RUN |-> run_cnt_q <= cfg.period); // R4
   AST_STOP_FINITE: assert property (@(posedge clk) disable iff (!rst_n)
      st_q == ST_STOP |-> cfg.rpt != '0); // R3
   AST_REP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RUN && cfg.rpt != '0) |-> rep_cnt_q <= cfg.rpt); // R3
   AST_CLR_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (run && clr_e) |=> st_q == ST_WAIT); // R6
   AST_EVT_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o |-> st_q == ST_RUN); // R5
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (!evt_o && !pin_o)); // R1
endmodule

// File: rtl/sync_wave_bank.sv
module sync_wave_bank
   import sync_wave_pkg::*;
#(
   parameter int NUM_GEN = 9,
   localparam int AW = $clog2(NUM_GEN + 1) + 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bank_en,
   input  logic               wr_en,
   input  logic [AW-1:0]      wr_addr,
   input  logic [31:0]        wr_data,
   output logic [NUM_GEN-1:0] gen_pin,
   output logic [NUM_GEN-1:0] gen_evt
);
   if (NUM_GEN < 2 || NUM_GEN > (1 << SRC_W) - 2) begin : g_bad_count
      $error("NUM_GEN out of range for the source code width");
   end
   if (W0_OSRC + SRC_W > 32 || W2_DN + EDG_W > 32 || EDG_W > CNT_W + 1) begin : g_bad_fields
      $error("configuration fields do not fit a 32-bit word");
   end

   gen_cfg_t           cfg [NUM_GEN];
   logic [NUM_GEN-1:0] inv;
   logic [NUM_GEN-1:0] raw;

   sync_wave_regs #(.NUM_GEN(NUM_GEN)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .bank_en (bank_en),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .cfg_q   (cfg),
      .inv_q   (inv)
   );

   for (genvar k = 0; k < NUM_GEN; k++) begin : g_gen
      sync_wave_gen #(.NUM_GEN(NUM_GEN)) u_gen (
         .clk     (clk),
         .rst_n   (rst_n),
         .run     (bank_en),
         .cfg     (cfg[k]),
         .evt_all (gen_evt),
         .evt_o   (gen_evt[k]),
         .pin_o   (raw[k])
      );
   end

   assign gen_pin = raw ^ inv;

   AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
      !bank_en |=> (gen_pin == inv && gen_evt == '0)); // R1
endmodule

// File: tb/sync_wave_bank_bench.sv
`timescale 1ns/1ps
module sync_wave_bank_bench;
   localparam int N = 9;
   logic clk = 1'b0, rst_n = 1'b0, bank_en = 1'b0, wr_en = 1'b0;
   logic [5:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [N-1:0] gen_pin, gen_evt;
   int checks = 0, failures = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   sync_wave_bank u_sync_wave_bank (
      .clk(clk), .rst_n(rst_n), .bank_en(bank_en), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .gen_pin(gen_pin), .gen_evt(gen_evt));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wr(input int gen, input int w, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = {gen[3:0], w[1:0]}; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic cfg_gen(input int gen, input int per, input int ofs, input int rs,
                          input int os, input int rpt, input int clr, input int up, input int dn);
      wr(gen, 0, {os[3:0], rs[3:0], ofs[11:0], per[11:0]});
      wr(gen, 1, {16'b0, clr[3:0], rpt[11:0]});
      wr(gen, 2, {6'b0, dn[9:0], 6'b0, up[9:0]});
   endtask

   task automatic stop_bank();
      @(negedge clk); bank_en = 1'b0; @(negedge clk);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check(gen_pin == '0, "R1 reset pins", int'(gen_pin), 0);
      check(gen_evt == '0, "R1 reset events", int'(gen_evt), 0);
   endtask

   // horizontal generator: line of 10, pulse 3 (down=5 half units)
   task automatic t_hsync(input bit poke);
      cfg_gen(1, 9, 0, 1, 1, 0, 0, 0, 5);
      @(negedge clk); bank_en = 1'b1;
      for (int k = 1; k <= 30; k++) begin
         @(posedge clk);
         if (poke && k == 5) begin
            #1 wr_en = 1'b1; wr_addr = {4'd1, 2'd0}; wr_data = 32'h0000_1003;
         end
         if (poke && k == 6) begin
            #1 wr_en = 1'b1; wr_addr = {4'd0, 2'd0}; wr_data = 32'h1FF;
         end
         if (poke && k == 7) begin
            #1 wr_en = 1'b0;
         end
         @(negedge clk);
         check(gen_pin[0] == (((k-1)%10) < 3), "R7 R10 R9 pulse width", gen_pin[0], ((k-1)%10) < 3);
         check(gen_evt[0] == (((k-1)%10) == 0), "R4 period events", gen_evt[0], ((k-1)%10) == 0);
         check(gen_pin[8] == 1'b0 && gen_evt[8] == 1'b0, "R2 code 0 silent", gen_pin[8], 0);
         if (poke && k > 6)
            check(gen_pin[N-1:1] == '0, "R9 invert write ignored", int'(gen_pin[N-1:1]), 0);
      end
      stop_bank();
   endtask

   // windowed generator cleared by generator 1, offset 4, repeat 3
   task automatic t_window();
      cfg_gen(1, 9, 0, 1, 1, 0, 0, 0, 5);
      cfg_gen(2, 0, 4, 1, 1, 3, 2, 0, 2);
      @(negedge clk); bank_en = 1'b1;
      for (int k = 1; k <= 30; k++) begin
         bit exp;
         @(posedge clk); @(negedge clk);
         exp = (k >= 2) && (((k-2)%10) >= 5) && (((k-2)%10) <= 7);
         check(gen_pin[1] == exp, "R3 R5 R6 window pin", gen_pin[1], exp);
         check(gen_evt[1] == exp, "R3 R5 window events", gen_evt[1], exp);
      end
      stop_bank();
   endtask

   // counter stepped on generator 1 events (line of 5), period 3 lines
   task automatic t_chain();
      cfg_gen(1, 4, 0, 1, 1, 0, 0, 0, 2);
      cfg_gen(3, 2, 0, 2, 2, 0, 0, 0, 2);
      @(negedge clk); bank_en = 1'b1;
      for (int k = 1; k <= 30; k++) begin
         bit exp;
         @(posedge clk); @(negedge clk);
         exp = (k >= 2) && ((((k-2)/5)%3) == 0);
         check(gen_pin[2] == exp, "R2 chained pin", gen_pin[2], exp);
         check(gen_evt[2] == ((k == 2) || (k == 17)), "R2 R4 chained events", gen_evt[2], (k == 2) || (k == 17));
      end
      stop_bank();
   endtask

   task automatic t_invert();
      cfg_gen(1, 9, 0, 1, 1, 0, 0, 0, 5);
      wr(0, 0, 32'h105);
      @(negedge clk);
      check(gen_pin == 9'h105, "R8 R1 idle pins show invert", int'(gen_pin), 'h105);
      bank_en = 1'b1;
      for (int k = 1; k <= 4; k++) begin
         @(posedge clk); @(negedge clk);
         check(gen_pin[0] == (k > 3), "R8 inverted pulse", gen_pin[0], k > 3);
      end
      stop_bank();
      wr(0, 0, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_reset();
      t_hsync(1'b0);
      t_hsync(1'b1);
      t_hsync(1'b0);
      t_window();
      t_chain();
      t_invert();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule